// File: doc/BRIEF.md
# Walsh-Hadamard Multi-User Chip Spreader

This block builds the code-division layer of a multicarrier downlink. For one group of subcarriers it takes one complex QPSK symbol from each of Nu users and returns Nu complex chips. Chip k is the sum, over all users j, of user j's symbol weighted by +1 or -1 from row j of a natural-order (Sylvester) Hadamard matrix. All users go through one radix-2 add/subtract butterfly network in log2(Nu) stages instead of one code multiply per user. The word grows by one bit at each stage, so no sum can overflow.

A used-subcarrier count fixed at build time is split into Nb = USED_SC / Nu groups. The block counts groups and marks the last output of the final group, which closes one multicarrier symbol. The code length is chosen at run time between 4 and 64. A receive-side mode runs the same network on equalised chips and returns only the selected user's bin divided by Nu. The length, the mode and the user are captured at the first sample of each symbol.

Samples arrive one per cycle on a valid/ready stream and leave on a second valid/ready stream. While a group's results drain, no new input is taken.

Top module: `wh_chip_spreader`

## Requirements
- R1: During and right after reset, in_ready_o is 1 and out_valid_o is 0. The group and sample counters start at zero.
- R2: The block takes exactly Nu samples per group, indexed in arrival order as user 0 up to user Nu-1. It then drops in_ready_o until the last output of the group has been transferred. in_ready_o and out_valid_o are never both 1.
- R3: In spread mode (despread_i = 0) the block emits Nu chips, k = 0 first. Chip k equals the sum over j of d_j * (-1)^popcount(j AND k), taken separately on the real and imaginary parts. Outputs are signed, SAMPLE_W+MAX_LOG bits wide, and never wrap, even when every input is at the negative full scale.
- R4: Nu = 2^len_log_i. A len_log_i below 2 is treated as 2 and a value above 6 as 6.
- R5: len_log_i, despread_i and user_sel_i are sampled only with the first sample of a symbol, when the group counter is zero. Changes later in the same symbol have no effect until the next symbol starts.
- R6: In despread mode (despread_i = 1) the group yields one output: the transform bin of the selected user, arithmetically shifted right by log2(Nu), which rounds toward minus infinity.
- R7: The selected user is user_sel_i with only its low log2(Nu) bits kept.
- R8: out_last_o is 1 on the final output of every group. out_sym_end_o is 1 only on the final output of group Nb-1, where Nb = USED_SC / Nu (192 by default). The next group then starts a new symbol.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_re_o, out_im_o, out_last_o and out_sym_end_o do not change.
- R10: Spreading the chips of a QPSK group (values of +1 or -1) a second time gives each original symbol times Nu. Despreading those chips for user u gives user u's original symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_log_i | input | 3 | log2 of the code length, clamped to 2..6 |
| despread_i | input | 1 | 0 = spread all users, 1 = despread one user |
| user_sel_i | input | 6 | User index for despread mode |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block accepts a sample |
| in_re_i | input | 8 | Input real part, signed |
| in_im_i | input | 8 | Input imaginary part, signed |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts output |
| out_re_o | output | 14 | Output real part, signed |
| out_im_o | output | 14 | Output imaginary part, signed |
| out_last_o | output | 1 | Final output of a group |
| out_sym_end_o | output | 1 | Final output of a symbol |

## Verification
A wrong butterfly sign or stride would corrupt specific chip indices within two cycles of the last input. Comparing every chip against a direct sum over the Hadamard rows finds the exact index at fault. A group counter or latched length that is off would show up as a misplaced out_sym_end_o or a wrong sample count per group, and that is visible within one symbol. The round trip through the transform, and the mid-symbol configuration change, expose stale or early latching of the configuration at the next group's outputs.

// File: rtl/wh_pkg.sv
package wh_pkg;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_CALC  = 2'd1,
    ST_DRAIN = 2'd2
  } wh_state_e;

  function automatic logic [7:0] wh_clamp(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/wh_fill_buf.sv
module wh_fill_buf #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned MAX_LOG  = 6,
  localparam int unsigned MAX_NU  = 1 << MAX_LOG
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [MAX_LOG-1:0]                 wr_idx_i,
  input  logic [SAMPLE_W-1:0]                wr_re_i,
  input  logic [SAMPLE_W-1:0]                wr_im_i,
  output logic [MAX_NU-1:0][SAMPLE_W-1:0]    buf_re_o,
  output logic [MAX_NU-1:0][SAMPLE_W-1:0]    buf_im_o
);

  logic [MAX_NU-1:0][SAMPLE_W-1:0] re_q, im_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q <= '0;
      im_q <= '0;
    end else if (wr_en_i) begin
      re_q[wr_idx_i] <= wr_re_i;
      im_q[wr_idx_i] <= wr_im_i;
    end
  end

  assign buf_re_o = re_q;
  assign buf_im_o = im_q;

endmodule

// File: rtl/wh_fht_net.sv
// Butterfly network in natural Hadamard order; stages at or above len_i pass through.
module wh_fht_net #(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned MAX_LOG = 6,
  parameter int unsigned LEN_W   = 3,
  localparam int unsigned MAX_NU = 1 << MAX_LOG,
  localparam int unsigned OUT_W  = IN_W + MAX_LOG
) (
  input  logic [LEN_W-1:0]               len_i,
  input  logic [MAX_NU-1:0][IN_W-1:0]    x_i,
  output logic [MAX_NU-1:0][OUT_W-1:0]   y_o
);

  for (genvar s = 0; s < MAX_LOG; s++) begin : g_stg
    localparam int unsigned W = IN_W + s + 1;
    localparam int unsigned H = 1 << s;
    logic [MAX_NU-1:0][W-2:0] prev;
    logic [MAX_NU-1:0][W-1:0] v;
    logic                     en;

    if (s == 0) begin : g_first
      assign prev = x_i;
    end else begin : g_next
      assign prev = g_stg[s-1].v;
    end

    assign en = (len_i > LEN_W'(s));

    for (genvar i = 0; i < MAX_NU; i++) begin : g_el
      if ((i & H) == 0) begin : g_lo
        assign v[i] = en ? ({prev[i][W-2], prev[i]} + {prev[i+H][W-2], prev[i+H]})
                         :  {prev[i][W-2], prev[i]};
      end else begin : g_hi
        assign v[i] = en ? ({prev[i-H][W-2], prev[i-H]} - {prev[i][W-2], prev[i]})
                         :  {prev[i][W-2], prev[i]};
      end
    end
  end

  assign y_o = g_stg[MAX_LOG-1].v;

endmodule

// File: rtl/wh_out_seq.sv
module wh_out_seq #(
  parameter int unsigned OUT_W   = 14,
  parameter int unsigned MAX_LOG = 6,
  parameter int unsigned LEN_W   = 3,
  localparam int unsigned MAX_NU = 1 << MAX_LOG
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [MAX_NU-1:0][OUT_W-1:0]    res_re_i,
  input  logic [MAX_NU-1:0][OUT_W-1:0]    res_im_i,
  input  logic [LEN_W-1:0]                len_i,
  input  logic                            desp_i,
  input  logic [MAX_LOG-1:0]              user_i,
  input  logic                            out_ready_i,
  output logic                            out_valid_o,
  output logic [OUT_W-1:0]                out_re_o,
  output logic [OUT_W-1:0]                out_im_o,
  output logic                            out_last_o
);

  logic [MAX_NU-1:0][OUT_W-1:0] re_q, im_q;
  logic [MAX_LOG-1:0]           idx_q;
  logic                         valid_q;
  logic [MAX_LOG:0]             nu_full;
  logic [MAX_LOG-1:0]           nu_m1;
  logic [OUT_W-1:0]             bin_re, bin_im;

  assign nu_full = (MAX_LOG+1)'(1) << len_i;
  assign nu_m1   = MAX_LOG'(nu_full - 1'b1);
  assign bin_re  = re_q[user_i];
  assign bin_im  = im_q[user_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q    <= '0;
      im_q    <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      re_q    <= res_re_i;
      im_q    <= res_im_i;
      idx_q   <= '0;
      valid_q <= 1'b1;
    end else if (valid_q && out_ready_i) begin
      if (out_last_o) valid_q <= 1'b0;
      else            idx_q   <= idx_q + 1'b1;
    end
  end

  assign out_valid_o = valid_q;
  assign out_last_o  = desp_i || (idx_q == nu_m1);
  assign out_re_o    = desp_i ? OUT_W'($signed(bin_re) >>> len_i) : re_q[idx_q];
  assign out_im_o    = desp_i ? OUT_W'($signed(bin_im) >>> len_i) : im_q[idx_q];

endmodule

// File: rtl/wh_chip_spreader.sv
module wh_chip_spreader #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned MAX_LOG  = 6,
  parameter int unsigned USED_SC  = 192,
  localparam int unsigned MAX_NU  = 1 << MAX_LOG,
  localparam int unsigned OUT_W   = SAMPLE_W + MAX_LOG,
  localparam int unsigned LEN_W   = $clog2(MAX_LOG + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LEN_W-1:0]     len_log_i,
  input  logic                 despread_i,
  input  logic [MAX_LOG-1:0]   user_sel_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [SAMPLE_W-1:0]  in_re_i,
  input  logic [SAMPLE_W-1:0]  in_im_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [OUT_W-1:0]     out_re_o,
  output logic [OUT_W-1:0]     out_im_o,
  output logic                 out_last_o,
  output logic                 out_sym_end_o
);
  import wh_pkg::*;

  localparam int unsigned MIN_LOG = 2;
  localparam int unsigned GRP_W   = $clog2((USED_SC >> MIN_LOG) + 1);

  wh_state_e                    state_q;
  logic [MAX_LOG-1:0]           fill_cnt_q;
  logic [GRP_W-1:0]             grp_cnt_q;
  logic [LEN_W-1:0]             len_q;
  logic                         desp_q;
  logic [MAX_LOG-1:0]           user_q;

  logic                         sym_first, accept, grp_done, sym_last;
  logic [LEN_W-1:0]             len_in, len_now;
  logic [MAX_LOG:0]             nu_in_full, nu_now_full;
  logic [MAX_LOG-1:0]           nu_m1_now, user_mask_in;
  logic [GRP_W-1:0]             nb_m1;

  logic [MAX_NU-1:0][SAMPLE_W-1:0] buf_re, buf_im;
  logic [MAX_NU-1:0][OUT_W-1:0]    res_re, res_im;

  assign len_in       = LEN_W'(wh_clamp(8'(len_log_i), 8'(MIN_LOG), 8'(MAX_LOG)));
  assign sym_first    = (fill_cnt_q == '0) && (grp_cnt_q == '0);
  assign len_now      = sym_first ? len_in : len_q;
  assign nu_in_full   = (MAX_LOG+1)'(1) << len_in;
  assign nu_now_full  = (MAX_LOG+1)'(1) << len_now;
  assign user_mask_in = MAX_LOG'(nu_in_full - 1'b1);
  assign nu_m1_now    = MAX_LOG'(nu_now_full - 1'b1);
  assign nb_m1        = GRP_W'((USED_SC >> len_q) - 1);

  assign in_ready_o = (state_q == ST_FILL);
  assign accept     = in_ready_o && in_valid_i;
  assign grp_done   = out_valid_o && out_ready_i && out_last_o;
  assign sym_last   = (grp_cnt_q == nb_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FILL;
      fill_cnt_q <= '0;
      grp_cnt_q  <= '0;
      len_q      <= LEN_W'(MIN_LOG);
      desp_q     <= 1'b0;
      user_q     <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: if (accept) begin
          if (sym_first) begin
            len_q  <= len_in;
            desp_q <= despread_i;
            user_q <= user_sel_i & user_mask_in;
          end
          if (fill_cnt_q == nu_m1_now) begin
            fill_cnt_q <= '0;
            state_q    <= ST_CALC;
          end else begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
          end
        end
        ST_CALC: state_q <= ST_DRAIN;
        ST_DRAIN: if (grp_done) begin
          state_q   <= ST_FILL;
          grp_cnt_q <= sym_last ? '0 : grp_cnt_q + 1'b1;
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  wh_fill_buf #(.SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG)) i_fill_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (accept),
    .wr_idx_i (fill_cnt_q),
    .wr_re_i  (in_re_i),
    .wr_im_i  (in_im_i),
    .buf_re_o (buf_re),
    .buf_im_o (buf_im)
  );

  wh_fht_net #(.IN_W(SAMPLE_W), .MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) i_fht_re (
    .len_i (len_q),
    .x_i   (buf_re),
    .y_o   (res_re)
  );

  wh_fht_net #(.IN_W(SAMPLE_W), .MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) i_fht_im (
    .len_i (len_q),
    .x_i   (buf_im),
    .y_o   (res_im)
  );

  wh_out_seq #(.OUT_W(OUT_W), .MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) i_out_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (state_q == ST_CALC),
    .res_re_i    (res_re),
    .res_im_i    (res_im),
    .len_i       (len_q),
    .desp_i      (desp_q),
    .user_i      (user_q),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_re_o    (out_re_o),
    .out_im_o    (out_im_o),
    .out_last_o  (out_last_o)
  );

  assign out_sym_end_o = out_valid_o && out_last_o && sym_last;

endmodule

// File: rtl/wh_chip_spreader_chk.sv
module wh_chip_spreader_chk #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned MAX_LOG  = 6,
  localparam int unsigned MAX_NU  = 1 << MAX_LOG,
  localparam int unsigned OUT_W   = SAMPLE_W + MAX_LOG
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_re_o,
  input logic [OUT_W-1:0] out_im_o,
  input logic             out_last_o,
  input logic             out_sym_end_o
);

  logic [MAX_LOG:0] in_cnt_q, out_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else begin
      if (out_valid_o && out_ready_i && out_last_o) in_cnt_q <= '0;
      else if (in_valid_i && in_ready_o)            in_cnt_q <= in_cnt_q + 1'b1;
      if (out_valid_o && out_ready_i)
        out_cnt_q <= out_last_o ? '0 : out_cnt_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_state: assert (in_ready_o && !out_valid_o);
  end

  a_r2_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  a_r2_back_to_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> in_ready_o && !out_valid_o);

  a_r2_in_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |-> in_cnt_q < (MAX_LOG+1)'(MAX_NU));

  a_r3_out_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_cnt_q < (MAX_LOG+1)'(MAX_NU));

  a_r8_sym_end_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sym_end_o |-> out_valid_o && out_last_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_re_o) && $stable(out_im_o)
                                    && $stable(out_last_o) && $stable(out_sym_end_o));

endmodule

bind wh_chip_spreader wh_chip_spreader_chk #(.SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_re_o      (out_re_o),
  .out_im_o      (out_im_o),
  .out_last_o    (out_last_o),
  .out_sym_end_o (out_sym_end_o)
);

// File: tb/test_wh_chip_spreader.sv
`timescale 1ns/1ps
module test_wh_chip_spreader;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  len_log_i = 3'd2;
  logic        despread_i = 1'b0;
  logic [5:0]  user_sel_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_re_i = '0, in_im_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [13:0] out_re_o, out_im_o;
  logic        out_last_o, out_sym_end_o;

  int n_chk = 0, n_err = 0;
  int g_re[64], g_im[64], cap_re[64], cap_im[64];
  int orig_re[64], orig_im[64], chip_re[64], chip_im[64];

  always #4 clk_i = ~clk_i;

  wh_chip_spreader i_wh_chip_spreader (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void fht(ref int a[64], input int n);
    for (int h = 1; h < n; h = h * 2)
      for (int i = 0; i < n; i++)
        if ((i & h) == 0) begin
          int x = a[i];
          int y = a[i+h];
          a[i]   = x + y;
          a[i+h] = x - y;
        end
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    out_ready_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic fill_rand(input int n, input bit qpsk);
    for (int i = 0; i < n; i++) begin
      if (qpsk) begin
        g_re[i] = ($urandom_range(0, 1) != 0) ? 1 : -1;
        g_im[i] = ($urandom_range(0, 1) != 0) ? 1 : -1;
      end else begin
        g_re[i] = int'($urandom_range(0, 255)) - 128;
        g_im[i] = int'($urandom_range(0, 255)) - 128;
      end
    end
  endtask

  // Sends 2^lg samples, collects outputs, compares against the direct model.
  task automatic run_group(input int lg, input bit desp, input int usr,
                           input bit exp_end, input string req);
    int n = 1 << lg;
    int e_re[64], e_im[64];
    int cnt = desp ? 1 : n;
    int got = 0;
    bit held = 0;
    logic [13:0] h_re = '0, h_im = '0;
    for (int i = 0; i < 64; i++) begin
      e_re[i] = (i < n) ? g_re[i] : 0;
      e_im[i] = (i < n) ? g_im[i] : 0;
    end
    fht(e_re, n);
    fht(e_im, n);
    if (desp) begin
      e_re[0] = e_re[usr] >>> lg;
      e_im[0] = e_im[usr] >>> lg;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_re_i = 8'(g_re[i]);
      in_im_i = 8'(g_im[i]);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(!in_ready_o, {req, " R2 ready low after group"}, int'(in_ready_o), 0);
    while (got < cnt) begin
      @(negedge clk_i);
      if (held && out_valid_o)
        chk(out_re_o == h_re && out_im_o == h_im, "R9 stall hold",
            int'($signed(out_re_o)), int'($signed(h_re)));
      held = 0;
      out_ready_i = ($urandom_range(0, 3) != 0);
      if (out_valid_o) begin
        if (out_ready_i) begin
          chk(int'($signed(out_re_o)) == e_re[got], {req, " re"}, int'($signed(out_re_o)), e_re[got]);
          chk(int'($signed(out_im_o)) == e_im[got], {req, " im"}, int'($signed(out_im_o)), e_im[got]);
          chk(out_last_o == (got == cnt - 1), "R8 last", int'(out_last_o), int'(got == cnt - 1));
          chk(out_sym_end_o == (exp_end && got == cnt - 1), "R8 sym_end",
              int'(out_sym_end_o), int'(exp_end && got == cnt - 1));
          chk(!in_ready_o, "R2 excl", int'(in_ready_o), 0);
          cap_re[got] = int'($signed(out_re_o));
          cap_im[got] = int'($signed(out_im_o));
          got++;
        end else begin
          held = 1;
          h_re = out_re_o;
          h_im = out_im_o;
        end
      end
    end
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk(in_ready_o && !out_valid_o, "R2 refill", int'(in_ready_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i);
    chk(in_ready_o && !out_valid_o, "R1 in reset", int'(out_valid_o), 0);
    do_reset();
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1 ready after reset", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R1 valid after reset", int'(out_valid_o), 0);

    // R3 R4: random spreading at every legal length
    for (int t = 0; t < 10; t++) begin
      int lg = 2 + (t % 5);
      do_reset();
      len_log_i = 3'(lg); despread_i = 1'b0;
      fill_rand(64, 0);
      run_group(lg, 0, 0, 0, "R3 spread");
    end

    // R6 R7: random despread with unmasked user index
    for (int t = 0; t < 10; t++) begin
      int lg = 2 + int'($urandom_range(0, 4));
      int u  = int'($urandom_range(0, 63));
      do_reset();
      len_log_i = 3'(lg); despread_i = 1'b1; user_sel_i = 6'(u);
      fill_rand(64, 0);
      run_group(lg, 1, u & ((1 << lg) - 1), 0, "R6 R7 despread");
    end

    // R4: clamping
    do_reset();
    len_log_i = 3'd0; despread_i = 1'b0; fill_rand(64, 0);
    run_group(2, 0, 0, 0, "R4 clamp low");
    do_reset();
    len_log_i = 3'd7; fill_rand(64, 0);
    run_group(6, 0, 0, 0, "R4 clamp high");

    // R3: full-scale corners
    do_reset();
    len_log_i = 3'd6;
    for (int i = 0; i < 64; i++) begin g_re[i] = -128; g_im[i] = 127; end
    run_group(6, 0, 0, 0, "R3 full scale");
    chk(cap_re[0] == -8192, "R3 no overflow", cap_re[0], -8192);
    do_reset();
    despread_i = 1'b1; user_sel_i = 6'd0;
    run_group(6, 1, 0, 0, "R6 full scale");
    // R6: floor rounding of a negative bin
    do_reset();
    len_log_i = 3'd2; despread_i = 1'b1; user_sel_i = 6'd0;
    for (int i = 0; i < 64; i++) begin g_re[i] = 0; g_im[i] = 0; end
    g_re[0] = -1; g_im[1] = 3;
    run_group(2, 1, 0, 0, "R6 floor");
    chk(cap_re[0] == -1, "R6 floor value", cap_re[0], -1);

    // R5 R8: config change mid-symbol, symbol of 3 groups at Nu=64
    do_reset();
    len_log_i = 3'd6; despread_i = 1'b0;
    fill_rand(64, 0); run_group(6, 0, 0, 0, "R8 g0");
    len_log_i = 3'd2; despread_i = 1'b1; user_sel_i = 6'd3;
    fill_rand(64, 0); run_group(6, 0, 0, 0, "R5 g1 ignored cfg");
    fill_rand(64, 0); run_group(6, 0, 0, 1, "R8 g2 sym end");
    fill_rand(64, 0); run_group(2, 1, 3, 0, "R5 new symbol cfg");

    // R8: Nu=32 gives six groups
    do_reset();
    len_log_i = 3'd5; despread_i = 1'b0;
    for (int gi = 0; gi < 6; gi++) begin
      fill_rand(64, 0);
      run_group(5, 0, 0, gi == 5, "R8 nb=6");
    end

    // R10: round trip with QPSK at Nu=16
    do_reset();
    len_log_i = 3'd4; despread_i = 1'b0;
    fill_rand(64, 1);
    for (int i = 0; i < 16; i++) begin orig_re[i] = g_re[i]; orig_im[i] = g_im[i]; end
    run_group(4, 0, 0, 0, "R10 spread");
    for (int i = 0; i < 16; i++) begin
      chip_re[i] = cap_re[i]; chip_im[i] = cap_im[i];
      g_re[i] = cap_re[i]; g_im[i] = cap_im[i];
    end
    run_group(4, 0, 0, 0, "R10 respread");
    for (int i = 0; i < 16; i++) begin
      chk(cap_re[i] == 16 * orig_re[i], "R10 twice re", cap_re[i], 16 * orig_re[i]);
      chk(cap_im[i] == 16 * orig_im[i], "R10 twice im", cap_im[i], 16 * orig_im[i]);
    end
    do_reset();
    len_log_i = 3'd4; despread_i = 1'b1; user_sel_i = 6'd5;
    for (int i = 0; i < 16; i++) begin g_re[i] = chip_re[i]; g_im[i] = chip_im[i]; end
    run_group(4, 1, 5, 0, "R10 despread");
    chk(cap_re[0] == orig_re[5], "R10 user re", cap_re[0], orig_re[5]);
    chk(cap_im[0] == orig_im[5], "R10 user im", cap_im[0], orig_im[5]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule